// File: doc/BRIEF.md
# Reset Strap Capture Controller

This block reads a group of shared configuration pins while the synchronous hardware reset is held. When reset is released it keeps their values in configuration registers. The captured values set five things: a 5-bit management address, an interface isolate flag, the link modes offered for auto-negotiation, the LED operating mode and the automatic crossover enable. Once capture is complete, the same pins become outputs for the core's normal signals. The block controls their output enables.

Each strap input passes through a two-flop synchronizer. The capture registers load the synchronized value on every clock while reset is high, so the value kept is the one present on the last reset clock. A small write port lets software later change the address, the LED mode and the advertisement field. The crossover enable and the isolate flag can only be changed by another hardware reset. The isolate decision comes from the strapped address alone.

Top module: `strap_capture_ctrl`

## Requirements
- R1: Strap bit positions are: address in bits [4:0], auto-negotiation strap in bit 5, LED strap in bit 6, crossover strap in bit 7. Each bit goes through two synchronizer flops. The captured value is the synchronized value on the last rising edge with `rst` high, so a pin change one clock before release is not captured. Pin changes after release have no effect.
- R2: `addr_o` takes the strapped address, which may be any value from 0 to 31.
- R3: `isolate_o` is 1 exactly when the strapped address is 0. While it is 1, `pin_oe_o` is all zeros.
- R4: Writing address 0 through the write port does not set `isolate_o`. Writing a nonzero address does not clear it. Only a new reset can change `isolate_o`.
- R5: `adv_o` bits are {100 full, 100 half, 10 full, 10 half}. Auto-negotiation strap 0 gives 4'b0101 and strap 1 gives 4'b1111.
- R6: LED strap 1 gives `led_mode_o` = 1 and LED strap 0 gives `led_mode_o` = 2. A write can set any 2-bit mode value.
- R7: `mdix_en_o` equals the crossover strap (1 enables, 0 disables) and no write changes it.
- R8: `pin_oe_o` is zero during reset and on the first clock after release. It becomes all ones from the second clock after release, unless isolated. `pin_o` is `pin_out_i` registered by one clock.
- R9: Write port selects are 0 = address (`wr_data[4:0]`), 1 = LED mode (`wr_data[1:0]`), 2 = advertisement (`wr_data[3:0]`), 3 = ignored. Writes take effect on the next clock edge and are ignored while `rst` is high.
- R10: The pull-default levels, strap 8'hE1, give address 1, advertisement 4'b1111, LED mode 1, crossover enabled and no isolate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| strap_pin_i | input | 8 | Levels read from the shared pins |
| pin_out_i | input | 8 | Normal output data for the shared pins |
| pin_o | output | 8 | Registered output data to the pads |
| pin_oe_o | output | 8 | Output enables for the pads (1 = drive) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select for the write |
| wr_data | input | 5 | Write data |
| addr_o | output | 5 | Management address |
| isolate_o | output | 1 | Interface isolate flag |
| adv_o | output | 4 | Advertised link modes |
| led_mode_o | output | 2 | LED operating mode |
| mdix_en_o | output | 1 | Automatic crossover enable |

## Verification
The assertions assume that `rst` is high on the first clock edge. They also assume that write-port inputs are never unknown outside reset, so the comparisons after a write are meaningful. The bench drives `rst` high from time zero and keeps each strap pattern for several clocks before release. The one exception is the late-change test, which exercises the synchronizer depth on purpose. The write inputs are driven to defined values at all times, and every change is made on the falling edge.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int ADDR_W = 5;
  localparam int ADV_W  = 4;
  localparam int LED_W  = 2;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LED  = 2'd1,
    SEL_ADV  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  localparam logic [LED_W-1:0] LED_MODE_ONE = 2'd1;
  localparam logic [LED_W-1:0] LED_MODE_TWO = 2'd2;

  function automatic logic [ADV_W-1:0] adv_from_strap(input logic an);
    return an ? 4'b1111 : 4'b0101;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        s1 <= d_i[g];
        s2 <= s1;
      end
      assign q_o[g] = s2;
    end
  endgenerate
endmodule

// File: rtl/strap_regs.sv
module strap_regs
  import strap_pkg::*;
#(
  parameter int AW = ADDR_W,
  localparam int NP = AW + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    strap_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [AW-1:0]    wr_data,
  output logic [AW-1:0]    addr_o,
  output logic             isolate_o,
  output logic [ADV_W-1:0] adv_o,
  output logic [LED_W-1:0] led_mode_o,
  output logic             mdix_en_o
);
  localparam int AN_BIT   = AW;
  localparam int LED_BIT  = AW + 1;
  localparam int MDIX_BIT = AW + 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o     <= strap_i[AW-1:0];
      isolate_o  <= (strap_i[AW-1:0] == '0);
      adv_o      <= adv_from_strap(strap_i[AN_BIT]);
      led_mode_o <= strap_i[LED_BIT] ? LED_MODE_ONE : LED_MODE_TWO;
      mdix_en_o  <= strap_i[MDIX_BIT];
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_ADDR: addr_o     <= wr_data;
        SEL_LED:  led_mode_o <= wr_data[LED_W-1:0];
        SEL_ADV:  adv_o      <= wr_data[ADV_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         isolate_i,
  input  logic [W-1:0] pin_out_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  logic done;

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      pin_oe_o <= '0;
    end else begin
      done     <= 1'b1;
      pin_oe_o <= (done && !isolate_i) ? '1 : '0;
    end
  end

  always_ff @(posedge clk) pin_o <= pin_out_i;
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
  import strap_pkg::*;
#(
  parameter int AW = ADDR_W,
  localparam int NP = AW + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    strap_pin_i,
  input  logic [NP-1:0]    pin_out_i,
  output logic [NP-1:0]    pin_o,
  output logic [NP-1:0]    pin_oe_o,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [AW-1:0]    wr_data,
  output logic [AW-1:0]    addr_o,
  output logic             isolate_o,
  output logic [ADV_W-1:0] adv_o,
  output logic [LED_W-1:0] led_mode_o,
  output logic             mdix_en_o
);
  logic [NP-1:0] strap_s;

  strap_sync #(.W(NP)) u_sync (
    .clk (clk),
    .d_i (strap_pin_i),
    .q_o (strap_s)
  );

  strap_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (strap_s),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .addr_o     (addr_o),
    .isolate_o  (isolate_o),
    .adv_o      (adv_o),
    .led_mode_o (led_mode_o),
    .mdix_en_o  (mdix_en_o)
  );

  pin_drive #(.W(NP)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .isolate_i (isolate_o),
    .pin_out_i (pin_out_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );
endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk #(
  parameter int AW = 5,
  localparam int NP = AW + 3
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] pin_oe_o,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic [AW-1:0] addr_o,
  input logic          isolate_o,
  input logic          mdix_en_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R8
  oe_off_after_reset_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> pin_oe_o == '0);

  // R3
  isolate_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    isolate_o |-> pin_oe_o == '0);

  // R4
  isolate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(isolate_o));

  // R7
  mdix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mdix_en_o));

  // R9
  addr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> addr_o == $past(wr_data));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(wr_sel) == 2'd0)) |-> $stable(addr_o));
endmodule

bind strap_capture_ctrl strap_capture_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pin_oe_o  (pin_oe_o),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .addr_o    (addr_o),
  .isolate_o (isolate_o),
  .mdix_en_o (mdix_en_o)
);

// File: tb/tb_strap_capture_ctrl.sv
module tb_strap_capture_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] strap_pin_i = 8'hE1;
  logic [7:0] pin_out_i = 8'h5A;
  logic [7:0] pin_o, pin_oe_o;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [4:0] wr_data = 5'd0;
  logic [4:0] addr_o;
  logic       isolate_o;
  logic [3:0] adv_o;
  logic [1:0] led_mode_o;
  logic       mdix_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  strap_capture_ctrl dut (
    .clk(clk), .rst(rst), .strap_pin_i(strap_pin_i), .pin_out_i(pin_out_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .addr_o(addr_o), .isolate_o(isolate_o), .adv_o(adv_o),
    .led_mode_o(led_mode_o), .mdix_en_o(mdix_en_o)
  );

  // {strap, addr, adv, led, mdix, iso}
  localparam int NV = 5;
  localparam logic [20:0] VEC [NV] = '{
    {8'hE1, 5'd1,  4'hF, 2'd1, 1'b1, 1'b0},
    {8'h00, 5'd0,  4'h5, 2'd2, 1'b0, 1'b1},
    {8'h9F, 5'd31, 4'h5, 2'd2, 1'b1, 1'b0},
    {8'h6A, 5'd10, 4'hF, 2'd1, 1'b0, 1'b0},
    {8'hA0, 5'd0,  4'hF, 2'd2, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic reset_with(input logic [7:0] s);
    @(negedge clk);
    strap_pin_i = s;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write(input logic [1:0] sel, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 oe in reset", pin_oe_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      reset_with(v[20:13]);
      @(negedge clk);
      chk("R8 oe first clock", pin_oe_o, 0);
      chk("R2 addr", addr_o, v[12:8]);
      chk("R5 adv", adv_o, v[7:4]);
      chk("R6 led", led_mode_o, v[3:2]);
      chk("R7 mdix", mdix_en_o, v[1]);
      chk("R3 isolate", isolate_o, v[0]);
      @(negedge clk);
      chk("R8/R3 oe second clock", pin_oe_o, v[0] ? 0 : 8'hFF);
      chk("R8 pin_o", pin_o, 8'h5A);
    end

    // R10 default levels
    reset_with(8'hE1);
    repeat (2) @(negedge clk);
    chk("R10 defaults", {addr_o, adv_o, led_mode_o, mdix_en_o, isolate_o},
        {5'd1, 4'hF, 2'd1, 1'b1, 1'b0});

    // R1 pins after release have no effect
    strap_pin_i = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 post-release pins", {addr_o, mdix_en_o, isolate_o}, {5'd1, 1'b1, 1'b0});

    // R4 write address 0 does not isolate; R9 address write
    write(2'd0, 5'd0);
    chk("R9 addr write", addr_o, 0);
    chk("R4 no isolate on write 0", isolate_o, 0);
    @(negedge clk);
    chk("R4 oe kept", pin_oe_o, 8'hFF);

    // R6/R9 led and adv writes, R9 sel 3 ignored
    write(2'd1, 5'd3);
    chk("R6 led write 3", led_mode_o, 3);
    write(2'd2, 5'd6);
    chk("R9 adv write", adv_o, 6);
    write(2'd3, 5'd31);
    chk("R9 sel3 ignored", {addr_o, adv_o, led_mode_o, mdix_en_o},
        {5'd0, 4'd6, 2'd3, 1'b1});
    pin_out_i = 8'hC3;
    @(negedge clk);
    chk("R8 pin_o follows", pin_o, 8'hC3);

    // R4 nonzero write does not clear isolate
    reset_with(8'h00);
    repeat (2) @(negedge clk);
    write(2'd0, 5'd9);
    chk("R4 addr nonzero", addr_o, 9);
    chk("R4 isolate held", isolate_o, 1);
    chk("R3 oe off in isolate", pin_oe_o, 0);

    // R9 writes during reset ignored
    @(negedge clk);
    rst = 1'b1; strap_pin_i = 8'h6A;
    repeat (4) @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 5'd17;
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R9 write in reset ignored", addr_o, 10);

    // R1 late change one clock before release is not captured
    @(negedge clk);
    rst = 1'b1; strap_pin_i = 8'hE1;
    repeat (5) @(negedge clk);
    strap_pin_i = 8'h9F;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 late change", {addr_o, adv_o, led_mode_o}, {5'd1, 4'hF, 2'd1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule